// File: doc/BRIEF.md
# DAC Conversion Sequencer With Settling Timer

This block is the digital control core of a memory-mapped digital-to-analog converter. Software writes a 16-bit holding word over a small register bus. It also selects left or right alignment and an 8-bit or 12-bit code width. When an external trigger block sends a one-cycle start pulse, the sequencer extracts the conversion code from the holding word and loads it into a 12-bit output register. That register drives the analog converter and can be read from the bus, but not written.

After the load, the block counts a programmable settling interval with its busy flag high. When the interval ends it sets a finish flag, which can raise an interrupt. With DMA mode on, each load emits a one-cycle request for the next sample. A start that finds the holding word not refilled since the previous load is flagged as an under-run.

Register map (word addresses on `bus_addr`):
- 0: control. Bit 0 is enable, bit 1 the finish interrupt enable, bit 2 DMA mode, bit 3 the under-run interrupt enable, bit 4 left alignment, and bits [6:5] width select.
- 1: holding word.
- 2: output code, read-only.
- 3: status. Bit 0 is finish (write 1 to clear), bit 1 under-run (write 1 to clear), and bit 2 busy (read-only).
- 4: settling count, 10 bits.

Top module: `dac_conv_seq`

## Requirements
- R1: With width select 00 (or the reserved values 10/11, treated as 12-bit), a start takes the code from holding bits [11:0] when control bit 4 is 0, and from holding bits [15:4] when it is 1. The other holding bits are ignored.
- R2: With width select 01, a start takes the code from holding bits [7:0] when right-aligned, and from bits [15:8] when left-aligned, zero-extended to 12 bits.
- R3: The output code (port `code_out` and address 2) changes only on an accepted start. A bus write to address 2 has no effect.
- R4: After an accepted start, `busy` and status bit 2 stay high for exactly max(N,1) clock cycles, where N is the settling count at address 4.
- R5: The finish flag (status bit 0) sets in the cycle `busy` falls. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R6: An accepted start clears the finish flag in the same cycle that `busy` rises.
- R7: A start pulse that arrives while `busy` is high is ignored. It neither reloads the code nor restarts the count.
- R8: A start pulse is ignored while control bit 0 (enable) is 0.
- R9: `irq` is high exactly when (finish and control bit 1) or (under-run and control bit 3).
- R10: With control bit 2 set, `dma_req` is high for one cycle, in the cycle after each accepted start. It stays low with bit 2 clear.
- R11: With control bit 2 set, an accepted start that comes with no write to address 1 since the previous accepted start (or since reset) sets the under-run flag (status bit 1). Writing 1 to status bit 1 clears it.
- R12: After reset, every register reads 0 and `busy`, `irq`, `dma_req` and `code_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | One-cycle conversion start from the trigger logic |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr`, combinational |
| code_out | output | 12 | Code presented to the analog converter |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | Request for the next holding word |

## Verification
Every result here is due one edge after its stimulus: a start seen at edge E loads `code_out`, raises `busy`, clears the finish flag and pulses `dma_req` at E. A bus write takes effect at the edge that samples it. `busy` falls, and the finish flag rises, max(N,1) edges after the accepting edge. The bench drives inputs 1 time unit after a rising edge and samples 1 time unit after the following rising edge. It counts edges explicitly when it measures the busy window, so each check lands in the first cycle a result is due. `bus_rdata` is combinational, so reads sample after a short settle with no clock edge.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
    localparam int HOLD_W   = 16;
    localparam int CODE_W   = 12;
    localparam int NARROW_W = 8;
    localparam int SETTLE_W = 10;
    localparam int ADDR_W   = 3;

    typedef logic [HOLD_W-1:0]   hold_t;
    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [SETTLE_W-1:0] settle_t;
    typedef logic [ADDR_W-1:0]   addr_t;

    typedef enum logic [1:0] {
        WID_FULL   = 2'b00,
        WID_NARROW = 2'b01,
        WID_RSV_A  = 2'b10,
        WID_RSV_B  = 2'b11
    } width_e;

    // packed MSB first: wsel [6:5], left [4], udr_ie [3], dma_en [2], done_ie [1], enable [0]
    typedef struct packed {
        width_e wsel;
        logic   left;
        logic   udr_ie;
        logic   dma_en;
        logic   done_ie;
        logic   enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam addr_t A_CTRL   = addr_t'(0);
    localparam addr_t A_HOLD   = addr_t'(1);
    localparam addr_t A_CODE   = addr_t'(2);
    localparam addr_t A_STAT   = addr_t'(3);
    localparam addr_t A_SETTLE = addr_t'(4);

    localparam int ST_DONE = 0;
    localparam int ST_UDR  = 1;

    // Select the conversion code from the holding word for the given alignment and width.
    function automatic code_t pick_code(input hold_t word, input logic left, input width_e wsel);
        code_t res;
        res = '0;
        if (wsel == WID_NARROW) begin
            if (left) res[NARROW_W-1:0] = word[HOLD_W-1 -: NARROW_W];
            else      res[NARROW_W-1:0] = word[NARROW_W-1:0];
        end else begin
            if (left) res = word[HOLD_W-1 -: CODE_W];
            else      res = word[CODE_W-1:0];
        end
        return res;
    endfunction
endpackage

// File: rtl/dac_seq_regs.sv
module dac_seq_regs
    import dac_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_we,
    input  addr_t   bus_addr,
    input  hold_t   bus_wdata,
    output ctrl_t   cfg,
    output hold_t   hold,
    output settle_t settle,
    output logic    hold_wr,
    output logic    clr_done,
    output logic    clr_udr
);
    logic wr_stat;

    assign hold_wr  = bus_we && (bus_addr == A_HOLD);
    assign wr_stat  = bus_we && (bus_addr == A_STAT);
    assign clr_done = wr_stat && bus_wdata[ST_DONE];
    assign clr_udr  = wr_stat && bus_wdata[ST_UDR];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            hold   <= '0;
            settle <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL:   cfg    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_HOLD:   hold   <= bus_wdata;
                A_SETTLE: settle <= bus_wdata[SETTLE_W-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/dac_seq_core.sv
module dac_seq_core
    import dac_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_pulse,
    input  logic    enable,
    input  logic    dma_en,
    input  logic    left,
    input  width_e  wsel,
    input  hold_t   hold,
    input  settle_t settle,
    input  logic    hold_wr,
    input  logic    clr_done,
    input  logic    clr_udr,
    output code_t   code,
    output logic    busy,
    output logic    done,
    output logic    udr,
    output logic    dma_req
);
    settle_t cnt_q;
    logic    refilled_q;
    logic    accept;
    logic    expire;

    assign accept = start_pulse && enable && !busy;
    assign expire = busy && (cnt_q >= settle);

    always_ff @(posedge clk) begin
        if (rst) begin
            code       <= '0;
            busy       <= 1'b0;
            cnt_q      <= '0;
            done       <= 1'b0;
            udr        <= 1'b0;
            dma_req    <= 1'b0;
            refilled_q <= 1'b0;
        end else begin
            dma_req <= accept && dma_en;

            if (accept) begin
                code  <= pick_code(hold, left, wsel);
                busy  <= 1'b1;
                cnt_q <= settle_t'(1);
            end else if (expire) begin
                busy  <= 1'b0;
            end else if (busy) begin
                cnt_q <= cnt_q + settle_t'(1);
            end

            if (accept)        done <= 1'b0;
            else if (expire)   done <= 1'b1;
            else if (clr_done) done <= 1'b0;

            if (accept && dma_en && !refilled_q) udr <= 1'b1;
            else if (clr_udr)                    udr <= 1'b0;

            if (hold_wr)     refilled_q <= 1'b1;
            else if (accept) refilled_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dac_conv_seq.sv
module dac_conv_seq
    import dac_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_pulse,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [11:0] code_out,
    output logic        busy,
    output logic        irq,
    output logic        dma_req
);
    ctrl_t   cfg;
    hold_t   hold;
    settle_t settle;
    logic    hold_wr, clr_done, clr_udr;
    logic    done_flag, udr_flag;

    dac_seq_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cfg      (cfg),
        .hold     (hold),
        .settle   (settle),
        .hold_wr  (hold_wr),
        .clr_done (clr_done),
        .clr_udr  (clr_udr)
    );

    dac_seq_core core_i (
        .clk        (clk),
        .rst        (rst),
        .start_pulse(start_pulse),
        .enable     (cfg.enable),
        .dma_en     (cfg.dma_en),
        .left       (cfg.left),
        .wsel       (cfg.wsel),
        .hold       (hold),
        .settle     (settle),
        .hold_wr    (hold_wr),
        .clr_done   (clr_done),
        .clr_udr    (clr_udr),
        .code       (code_out),
        .busy       (busy),
        .done       (done_flag),
        .udr        (udr_flag),
        .dma_req    (dma_req)
    );

    assign irq = (done_flag && cfg.done_ie) || (udr_flag && cfg.udr_ie);

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = HOLD_W'(cfg);
            A_HOLD:   bus_rdata = hold;
            A_CODE:   bus_rdata = HOLD_W'(code_out);
            A_STAT:   bus_rdata = HOLD_W'({busy, udr_flag, done_flag});
            A_SETTLE: bus_rdata = HOLD_W'(settle);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dac_conv_seq_chk.sv
module dac_conv_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        busy,
    input logic        done_flag,
    input logic [11:0] code_out,
    input logic        dma_req
);
    // R7: while a conversion runs the output code cannot be reloaded
    assert_code_frozen_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(code_out));

    // R5, R6: finish and busy are never high together
    assert_done_busy_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(done_flag && busy));

    // R5: finish rises only as busy falls
    assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $fell(busy));

    // R10: request accompanies a freshly started conversion and lasts one cycle
    assert_req_with_busy_R10: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> busy);
    assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req);

    // R8: no conversion begins while disabled
    assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (!enable && !busy) |=> !busy);
endmodule

bind dac_conv_seq dac_conv_seq_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg.enable),
    .busy     (busy),
    .done_flag(done_flag),
    .code_out (code_out),
    .dma_req  (dma_req)
);

// File: tb/dac_conv_seq_tb_top.sv
module dac_conv_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_pulse = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [11:0] code_out;
    logic        busy, irq, dma_req;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_conv_seq dut_i (
        .clk(clk), .rst(rst), .start_pulse(start_pulse),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .code_out(code_out), .busy(busy),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
        tick();
        bus_we = 1'b0; bus_wdata = 16'd0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 3'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic fire();
        start_pulse = 1'b1;
        tick();
        start_pulse = 1'b0;
    endtask

    // ticks until busy drops, capped
    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 2000) begin
            tick();
            n++;
        end
    endtask

    function automatic int expect_code(input int d, input int left, input int wsel);
        if (wsel == 1) return left ? ((d >> 8) & 'hFF) : (d & 'hFF);
        return left ? ((d >> 4) & 'hFFF) : (d & 'hFFF);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, n;
        int pats[6] = '{'hFFFF, 'h0000, 'hA5C3, 'h1234, 'h8001, 'h0FF0};
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R12: reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk("R12 reg read", v, 0);
        end
        chk("R12 busy", int'(busy), 0);
        chk("R12 irq", int'(irq), 0);
        chk("R12 dma_req", int'(dma_req), 0);
        chk("R12 code_out", int'(code_out), 0);

        // R1, R2, R3: extraction sweep over width x alignment x patterns
        wr(4, 2);
        for (int ws = 0; ws < 4; ws++) begin
            for (int lf = 0; lf < 2; lf++) begin
                wr(0, 1 | (lf << 4) | (ws << 5));
                for (int p = 0; p < 22; p++) begin
                    int d;
                    int e;
                    d = (p < 6) ? pats[p] : (1 << (p - 6));
                    e = expect_code(d, lf, ws);
                    wr(1, d);
                    fire();
                    chk(ws == 1 ? "R2 code_out" : "R1 code_out", int'(code_out), e);
                    rd(2, v);
                    chk("R3 code read", v, e);
                    wait_idle(n);
                end
            end
        end

        // R3: bus write to the output register is ignored
        wr(0, 1);
        wr(1, 'h0456);
        fire(); wait_idle(n);
        wr(2, 'hFFFF);
        chk("R3 code after write", int'(code_out), 'h456);
        rd(2, v);
        chk("R3 read after write", v, 'h456);

        // R4: busy window length over several settling counts
        begin
            int nlist[7] = '{0, 1, 2, 3, 7, 64, 1023};
            for (int i = 0; i < 7; i++) begin
                wr(4, nlist[i]);
                fire();
                rd(3, v);
                chk("R4 status busy bit", (v >> 2) & 1, 1);
                wait_idle(n);
                chk("R4 busy cycles", n, (nlist[i] < 1) ? 1 : nlist[i]);
            end
        end

        // R5, R9: finish flag, interrupt gating, write-1-to-clear
        wr(4, 3);
        wr(0, 1);
        fire(); wait_idle(n);
        rd(3, v);
        chk("R5 done set", v & 1, 1);
        chk("R9 irq masked", int'(irq), 0);
        wr(0, 3);
        chk("R9 irq on done", int'(irq), 1);
        wr(3, 0);
        rd(3, v);
        chk("R5 write 0 keeps done", v & 1, 1);
        wr(3, 1);
        rd(3, v);
        chk("R5 w1c done", v & 1, 0);
        chk("R9 irq cleared", int'(irq), 0);

        // R6: new start clears finish
        fire(); wait_idle(n);
        chk("R6 irq before restart", int'(irq), 1);
        fire();
        rd(3, v);
        chk("R6 done cleared on start", v & 7, 4);
        chk("R6 irq after start", int'(irq), 0);
        wait_idle(n);

        // R7: start while busy ignored
        wr(4, 5);
        wr(1, 'h0123);
        fire();            // accepted at E0
        wr(1, 'h0ABC);     // E1
        fire();            // E2, ignored
        chk("R7 code kept", int'(code_out), 'h123);
        wait_idle(n);
        chk("R7 no restart", n, 3);
        chk("R7 code after idle", int'(code_out), 'h123);
        fire();
        chk("R7 next start loads", int'(code_out), 'hABC);
        wait_idle(n);

        // R8: disabled ignores starts
        wr(0, 0);
        wr(1, 'h0777);
        fire();
        chk("R8 busy stays low", int'(busy), 0);
        chk("R8 code unchanged", int'(code_out), 'hABC);

        // R10, R11, R9: DMA request and under-run
        wr(4, 2);
        wr(0, 1 | 4 | 8);
        wr(1, 'h0321);
        fire();
        chk("R10 dma_req pulse", int'(dma_req), 1);
        rd(3, v);
        chk("R11 no udr after refill", (v >> 1) & 1, 0);
        tick();
        chk("R10 dma_req single", int'(dma_req), 0);
        wait_idle(n);
        fire();
        chk("R10 dma_req second", int'(dma_req), 1);
        rd(3, v);
        chk("R11 udr set", (v >> 1) & 1, 1);
        chk("R9 irq on udr", int'(irq), 1);
        wait_idle(n);
        wr(3, 2);
        rd(3, v);
        chk("R11 udr w1c", v & 3, 1);
        chk("R9 irq after udr clear", int'(irq), 0);
        wr(0, 1 | 8);
        fire();
        chk("R10 no req without dma", int'(dma_req), 0);
        rd(3, v);
        chk("R11 no udr without dma", (v >> 1) & 1, 0);
        wait_idle(n);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule